// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous two-port byte memory. A left and a right port each have their own active-low chip enable, write enable, output enable, address, write data, registered read data and active-low interrupt output. Both ports can read and write any location in the same cycle.

The two highest addresses are mailboxes. The all-ones address is the mailbox toward the right port, and the all-ones-minus-one address is the mailbox toward the left port. The left port writes the all-ones address to raise the right port's interrupt. The right port reads that address to acknowledge it, and the roles are mirrored for the other mailbox. The mailboxes also hold data like any other location, so the sender can leave a message byte together with the interrupt.

Each port has an active-low busy input, driven by contention logic outside this block. While it is low, an access by that port still moves data but changes no interrupt flag. Address width `ADDR_W` defaults to 11. An 8K x 8 instance sets `ADDR_W` to 13.

Top module: `dpram_mbox`

## Requirements
- R1: While `rst_ni` is low, and at release, both interrupt outputs are high and both read-data outputs are zero.
- R2: A write access (`ce_ni`=0, `we_ni`=0) stores the byte at the rising edge. A read access (`ce_ni`=0, `we_ni`=1, `oe_ni`=0) presents that location's byte on the port's read data one cycle later. This holds for every address, the mailboxes included.
- R3: In any cycle that is not a read access of a port, that port's read data is zero in the following cycle.
- R4: A left write to address all-ones, with `l_busy_ni` high, drives `r_int_no` low from the next cycle.
- R5: A right read of address all-ones, with `r_busy_ni` high, returns `r_int_no` high from the next cycle.
- R6: A right write to address all-ones-minus-one, with `r_busy_ni` high, drives `l_int_no` low from the next cycle. A left read of that address, with `l_busy_ni` high, returns `l_int_no` high.
- R7: A set or clear access whose own port's busy input is low leaves the interrupt flag unchanged. The data part of the access still happens.
- R8: When one port sets a flag in the same cycle that the other port clears it, the flag ends set.
- R9: When both ports write the same address in the same cycle, the left byte is kept. A read in the same cycle as a write to the same address returns the old byte.
- R10: An interrupt flag changes only through its own set and clear accesses. A read of a mailbox by the sending port, or a write to a mailbox by the receiving port, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_we_ni | input | 1 | Left write enable, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_ni | input | 1 | Left busy, active low, blocks flag changes |
| l_rdata_o | output | DATA_W | Left registered read data |
| l_int_no | output | 1 | Interrupt to left port, active low |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_we_ni | input | 1 | Right write enable, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_ni | input | 1 | Right busy, active low, blocks flag changes |
| r_rdata_o | output | DATA_W | Right registered read data |
| r_int_no | output | 1 | Interrupt to right port, active low |

## Verification
The assertions check every cycle that a qualifying set access drives the interrupt output low in the next cycle, and that a clear access with no competing set drives it high. They also check that an interrupt output holds when neither access is present, which covers the busy blocking and the wrong-port accesses, and that read data falls to zero after a non-read cycle. Stored contents cannot be seen from a single cycle. The bench's reference model shows them: bytes written and read back through mailboxes and ordinary addresses, the left port winning a same-address write, and read-old-data on a same-cycle collision.

// File: rtl/dpram_mbox_pkg.sv
package dpram_mbox_pkg;

  localparam int unsigned NUM_SIDES = 2;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // decoded access of one port
  typedef struct packed {
    logic wr;
    logic rd;
    logic set;
    logic clr;
  } acc_t;

  // mailbox this side writes to interrupt the other side
  function automatic int unsigned send_addr(input int unsigned side, input int unsigned aw);
    return (side == 0) ? ((32'd1 << aw) - 1) : ((32'd1 << aw) - 2);
  endfunction

  // mailbox this side reads to acknowledge its own interrupt
  function automatic int unsigned recv_addr(input int unsigned side, input int unsigned aw);
    return send_addr(NUM_SIDES - 1 - side, aw);
  endfunction

endpackage

// File: rtl/dpram_mbox_port.sv
module dpram_mbox_port
  import dpram_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter logic [ADDR_W-1:0] SEND_ADDR = '1,
  parameter logic [ADDR_W-1:0] RECV_ADDR = '0
) (
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              busy_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);

  logic wr, rd;

  assign wr = ~ce_ni & ~we_ni;
  assign rd = ~ce_ni & we_ni & ~oe_ni;

  always_comb begin
    acc_o     = '0;
    acc_o.wr  = wr;
    acc_o.rd  = rd;
    acc_o.set = wr & busy_ni & (addr_i == SEND_ADDR);
    acc_o.clr = rd & busy_ni & (addr_i == RECV_ADDR);
  end

endmodule

// File: rtl/dpram_mbox_flag.sv
module dpram_mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no
);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;   // set beats clear
    else if (clr_i) flag_q <= 1'b0;
  end

  assign int_no = ~flag_q;

endmodule

// File: rtl/dpram_mbox_mem.sv
module dpram_mbox_mem
  import dpram_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SIDES-1:0] wr_i,
  input  logic [NUM_SIDES-1:0] rd_i,
  input  logic [ADDR_W-1:0] addr_i  [NUM_SIDES],
  input  logic [DATA_W-1:0] wdata_i [NUM_SIDES],
  output logic [DATA_W-1:0] rdata_o [NUM_SIDES]
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right first, left last: left wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (wr_i[SIDE_R]) mem_q[addr_i[SIDE_R]] <= wdata_i[SIDE_R];
    if (wr_i[SIDE_L]) mem_q[addr_i[SIDE_L]] <= wdata_i[SIDE_L];
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_rd
    logic [DATA_W-1:0] rdata_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (rd_i[s]) rdata_q <= mem_q[addr_i[s]];
      else              rdata_q <= '0;
    end
    assign rdata_o[s] = rdata_q;
  end

endmodule

// File: rtl/dpram_mbox.sv
module dpram_mbox
  import dpram_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_ni,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_int_no,
  input  logic              r_ce_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_ni,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_int_no
);

  logic [NUM_SIDES-1:0] ce_n, we_n, oe_n, busy_n, wr, rd, int_n;
  logic [ADDR_W-1:0]    addr  [NUM_SIDES];
  logic [DATA_W-1:0]    wdata [NUM_SIDES];
  logic [DATA_W-1:0]    rdata [NUM_SIDES];
  acc_t                 acc   [NUM_SIDES];

  assign ce_n   = {r_ce_ni,   l_ce_ni};
  assign we_n   = {r_we_ni,   l_we_ni};
  assign oe_n   = {r_oe_ni,   l_oe_ni};
  assign busy_n = {r_busy_ni, l_busy_ni};
  assign addr[SIDE_L]  = l_addr_i;
  assign addr[SIDE_R]  = r_addr_i;
  assign wdata[SIDE_L] = l_wdata_i;
  assign wdata[SIDE_R] = r_wdata_i;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] SEND = ADDR_W'(send_addr(s, ADDR_W));
    localparam logic [ADDR_W-1:0] RECV = ADDR_W'(recv_addr(s, ADDR_W));

    dpram_mbox_port #(
      .ADDR_W    (ADDR_W),
      .SEND_ADDR (SEND),
      .RECV_ADDR (RECV)
    ) i_port (
      .ce_ni   (ce_n[s]),
      .we_ni   (we_n[s]),
      .oe_ni   (oe_n[s]),
      .busy_ni (busy_n[s]),
      .addr_i  (addr[s]),
      .acc_o   (acc[s])
    );

    assign wr[s] = acc[s].wr;
    assign rd[s] = acc[s].rd;

    // flag toward side s: raised by the opposite side, acknowledged by s
    dpram_mbox_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (acc[NUM_SIDES-1-s].set),
      .clr_i  (acc[s].clr),
      .int_no (int_n[s])
    );
  end

  dpram_mbox_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .rd_i    (rd),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign l_rdata_o = rdata[SIDE_L];
  assign r_rdata_o = rdata[SIDE_R];
  assign l_int_no  = int_n[SIDE_L];
  assign r_int_no  = int_n[SIDE_R];

endmodule

// File: rtl/dpram_mbox_chk.sv
module dpram_mbox_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_ce_ni,
  input logic              l_we_ni,
  input logic              l_oe_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_busy_ni,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              l_int_no,
  input logic              r_ce_ni,
  input logic              r_we_ni,
  input logic              r_oe_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_busy_ni,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic              r_int_no
);

  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [ADDR_W-1:0] TOP_M1 = TOP - 1'b1;

  logic l_rd, r_rd, l_set, r_set, l_clr, r_clr;

  assign l_rd  = !l_ce_ni && l_we_ni && !l_oe_ni;
  assign r_rd  = !r_ce_ni && r_we_ni && !r_oe_ni;
  assign l_set = !l_ce_ni && !l_we_ni && l_busy_ni && (l_addr_i == TOP);
  assign r_set = !r_ce_ni && !r_we_ni && r_busy_ni && (r_addr_i == TOP_M1);
  assign l_clr = l_rd && l_busy_ni && (l_addr_i == TOP_M1);
  assign r_clr = r_rd && r_busy_ni && (r_addr_i == TOP);

  AST_R_INT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_set |=> !r_int_no); // R4
  AST_R_INT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_clr && !l_set) |=> r_int_no); // R5
  AST_L_INT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_set |=> !l_int_no); // R8
  AST_L_INT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_clr && !r_set) |=> l_int_no); // R6
  AST_R_INT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_set && !r_clr) |=> $stable(r_int_no)); // R7
  AST_L_INT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_set && !l_clr) |=> $stable(l_int_no)); // R10
  AST_L_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rd |=> (l_rdata_o == '0)); // R3
  AST_R_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rd |=> (r_rdata_o == '0)); // R3

endmodule

bind dpram_mbox dpram_mbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .l_ce_ni   (l_ce_ni),
  .l_we_ni   (l_we_ni),
  .l_oe_ni   (l_oe_ni),
  .l_addr_i  (l_addr_i),
  .l_busy_ni (l_busy_ni),
  .l_rdata_o (l_rdata_o),
  .l_int_no  (l_int_no),
  .r_ce_ni   (r_ce_ni),
  .r_we_ni   (r_we_ni),
  .r_oe_ni   (r_oe_ni),
  .r_addr_i  (r_addr_i),
  .r_busy_ni (r_busy_ni),
  .r_rdata_o (r_rdata_o),
  .r_int_no  (r_int_no)
);

// File: tb/test_dpram_mbox.sv
module test_dpram_mbox;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int TOP = (1 << AW) - 1;
  localparam int TOP_M1 = TOP - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic l_ce_ni = 1, l_we_ni = 1, l_oe_ni = 1, l_busy_ni = 1;
  logic r_ce_ni = 1, r_we_ni = 1, r_oe_ni = 1, r_busy_ni = 1;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic [DW-1:0] l_wdata_i = '0, r_wdata_i = '0;
  logic [DW-1:0] l_rdata_o, r_rdata_o;
  logic l_int_no, r_int_no;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // reference state
  logic [DW-1:0] mem_m [int];
  bit m_lflag, m_rflag;
  logic [DW-1:0] m_lrd, m_rrd;
  bit m_lrd_ok, m_rrd_ok;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dpram_mbox #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_mbox (
    .clk_i, .rst_ni,
    .l_ce_ni, .l_we_ni, .l_oe_ni, .l_addr_i, .l_wdata_i, .l_busy_ni, .l_rdata_o, .l_int_no,
    .r_ce_ni, .r_we_ni, .r_oe_ni, .r_addr_i, .r_wdata_i, .r_busy_ni, .r_rdata_o, .r_int_no
  );

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit lr, rr, lw, rw, ls, rs, lc, rc;
    if (!rst_ni) begin
      m_lflag = 0; m_rflag = 0; m_lrd = 0; m_rrd = 0; m_lrd_ok = 1; m_rrd_ok = 1;
      return;
    end
    lw = !l_ce_ni && !l_we_ni;
    rw = !r_ce_ni && !r_we_ni;
    lr = !l_ce_ni && l_we_ni && !l_oe_ni;
    rr = !r_ce_ni && r_we_ni && !r_oe_ni;
    ls = lw && l_busy_ni && (int'(l_addr_i) == TOP);
    rs = rw && r_busy_ni && (int'(r_addr_i) == TOP_M1);
    lc = lr && l_busy_ni && (int'(l_addr_i) == TOP_M1);
    rc = rr && r_busy_ni && (int'(r_addr_i) == TOP);
    m_lrd_ok = 1; m_rrd_ok = 1;
    if (lr) begin
      m_lrd_ok = mem_m.exists(int'(l_addr_i));
      m_lrd = m_lrd_ok ? mem_m[int'(l_addr_i)] : '0;
    end else m_lrd = 0;
    if (rr) begin
      m_rrd_ok = mem_m.exists(int'(r_addr_i));
      m_rrd = m_rrd_ok ? mem_m[int'(r_addr_i)] : '0;
    end else m_rrd = 0;
    if (rw) mem_m[int'(r_addr_i)] = r_wdata_i;
    if (lw) mem_m[int'(l_addr_i)] = l_wdata_i;
    if (ls) m_rflag = 1; else if (rc) m_rflag = 0;
    if (rs) m_lflag = 1; else if (lc) m_lflag = 0;
  endtask

  task automatic compare();
    check("r_int_no", int'(r_int_no), int'(!m_rflag));
    check("l_int_no", int'(l_int_no), int'(!m_lflag));
    if (m_lrd_ok) check("l_rdata_o", int'(l_rdata_o), int'(m_lrd));
    if (m_rrd_ok) check("r_rdata_o", int'(r_rdata_o), int'(m_rrd));
  endtask

  task automatic step();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle();
    l_ce_ni = 1; l_we_ni = 1; l_oe_ni = 1; l_busy_ni = 1;
    r_ce_ni = 1; r_we_ni = 1; r_oe_ni = 1; r_busy_ni = 1;
  endtask

  task automatic lwr(input int a, input int d, input bit busy_n = 1);
    l_ce_ni = 0; l_we_ni = 0; l_oe_ni = 1; l_addr_i = AW'(a); l_wdata_i = DW'(d); l_busy_ni = busy_n;
  endtask
  task automatic lrd(input int a, input bit busy_n = 1);
    l_ce_ni = 0; l_we_ni = 1; l_oe_ni = 0; l_addr_i = AW'(a); l_busy_ni = busy_n;
  endtask
  task automatic rwr(input int a, input int d, input bit busy_n = 1);
    r_ce_ni = 0; r_we_ni = 0; r_oe_ni = 1; r_addr_i = AW'(a); r_wdata_i = DW'(d); r_busy_ni = busy_n;
  endtask
  task automatic rrd(input int a, input bit busy_n = 1);
    r_ce_ni = 0; r_we_ni = 1; r_oe_ni = 0; r_addr_i = AW'(a); r_busy_ni = busy_n;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset values
    cur_req = "R1";
    repeat (3) step();
    check("l_int_no", int'(l_int_no), 1);
    check("r_int_no", int'(r_int_no), 1);
    check("l_rdata_o", int'(l_rdata_o), 0);
    check("r_rdata_o", int'(r_rdata_o), 0);
    rst_ni = 1;
    step();

    // R2: ordinary locations and mailboxes carry data
    cur_req = "R2";
    lwr(5, 8'hA5); rwr(9, 8'h3C); step();
    idle(); lrd(9); rrd(5); step();
    check("l_rdata_o R2", int'(l_rdata_o), 8'h3C);
    check("r_rdata_o R2", int'(r_rdata_o), 8'hA5);

    // R3: output enable high gives zero data
    cur_req = "R3";
    idle(); l_ce_ni = 0; l_oe_ni = 1; l_addr_i = 5; step();
    check("l_rdata_o R3", int'(l_rdata_o), 0);

    // R4: left writes right mailbox
    cur_req = "R4";
    idle(); lwr(TOP, 8'h77); step();
    idle(); step();
    check("r_int_no R4", int'(r_int_no), 0);

    // R10: wrong-port accesses leave flag
    cur_req = "R10";
    lrd(TOP); rwr(TOP, 8'h11); step();
    idle(); step();
    check("r_int_no R10", int'(r_int_no), 0);

    // R7: clear blocked by right busy
    cur_req = "R7";
    rrd(TOP, 0); step();
    idle(); step();
    check("r_int_no R7", int'(r_int_no), 0);

    // R5: right acknowledges, data returned
    cur_req = "R5";
    rrd(TOP); step();
    check("r_rdata_o R5", int'(r_rdata_o), 8'h11);
    check("r_int_no R5", int'(r_int_no), 1);
    idle(); step();

    // R7: set blocked by left busy
    cur_req = "R7";
    lwr(TOP, 8'h22, 0); step();
    idle(); step();
    check("r_int_no R7 blocked set", int'(r_int_no), 1);

    // R6: right raises left, left acknowledges
    cur_req = "R6";
    rwr(TOP_M1, 8'h5A); step();
    check("l_int_no R6 set", int'(l_int_no), 0);
    idle(); lrd(TOP_M1); step();
    check("l_int_no R6 clr", int'(l_int_no), 1);
    check("l_rdata_o R6", int'(l_rdata_o), 8'h5A);
    idle(); step();

    // R8: set and clear in one cycle
    cur_req = "R8";
    lwr(TOP, 8'h01); step();
    lwr(TOP, 8'h02); rrd(TOP); step();
    check("r_rdata_o R8 old data", int'(r_rdata_o), 8'h01);
    check("r_int_no R8", int'(r_int_no), 0);
    idle(); rrd(TOP); step();
    idle(); step();

    // R9: same-address write collision
    cur_req = "R9";
    lwr(40, 8'hC1); rwr(40, 8'hD2); step();
    idle(); rrd(40); step();
    check("r_rdata_o R9", int'(r_rdata_o), 8'hC1);
    idle(); step();

    // mixed traffic biased toward the mailboxes
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 3);
      l_addr_i  = (sel == 0) ? AW'(TOP) : (sel == 1) ? AW'(TOP_M1) : AW'($urandom_range(0, 7));
      sel = $urandom_range(0, 3);
      r_addr_i  = (sel == 0) ? AW'(TOP) : (sel == 1) ? AW'(TOP_M1) : AW'($urandom_range(0, 7));
      l_ce_ni   = ($urandom_range(0, 4) == 0);
      r_ce_ni   = ($urandom_range(0, 4) == 0);
      l_we_ni   = $urandom_range(0, 1) != 0;
      r_we_ni   = $urandom_range(0, 1) != 0;
      l_oe_ni   = ($urandom_range(0, 3) == 0);
      r_oe_ni   = ($urandom_range(0, 3) == 0);
      l_busy_ni = ($urandom_range(0, 5) != 0);
      r_busy_ni = ($urandom_range(0, 5) != 0);
      l_wdata_i = DW'($urandom);
      r_wdata_i = DW'($urandom);
      step();
    end
    idle(); step();
    finish_run();
  end

endmodule